// File: doc/BRIEF.md
# Load/Store Alignment and Trap Unit

This unit sits between the execute stage of a small in-order pipeline and a 32-bit word-wide synchronous memory port. For each access presented by the execute stage it forms an effective address. In absolute mode the address is a base register plus a short source operand. In relative mode it is the program counter plus a sign-extended 19-bit offset. It then decides whether the access is legal for its size. A misaligned word or halfword access issues nothing to memory and raises a trap toward a fixed vector. Byte accesses are never checked.

A legal access issues one memory request and holds the pipeline for exactly that cycle, so every load or store costs one extra cycle. Stores drive a little-endian byte-enable and copy the byte or halfword into every lane that could receive it. Loads return their data one cycle after the request. The unit picks the addressed byte or halfword from the returned word, zero- or sign-extends it, and derives zero and negative flags from the result. The overflow and carry flags for a load are always cleared.

Top module: `ldst_unit`

## Requirements
- R1: The effective address is `baseVal + offsetVal` when `reqRelative` is 0, and `pcVal` plus `immRel` sign-extended from bit 18 when `reqRelative` is 1. The unit presents the address on `memAddr` with bits 1:0 forced to zero.
- R2: With the size code word (`reqSize` = 2, and code 3 behaves the same), an effective address whose bits 1:0 are not 00 causes a trap. In that cycle `trapTaken` = 1 and `trapVector` = 0x80000000, while `memReq` and `suspend` stay 0.
- R3: With the size code halfword (`reqSize` = 1), an effective address with bit 0 set causes a trap, with the same outputs as R2.
- R4: With the size code byte (`reqSize` = 0), the unit never traps, whatever the address.
- R5: A non-trapping access asserts `memReq` and `suspend` in the same cycle as `reqValid`, for that cycle only. `memWe` equals `reqIsStore`. When no request is presented, `memReq` and `suspend` are 0.
- R6: Byte lanes are little-endian: lane k is bits 8k+7:8k. A byte store enables only lane `ea[1:0]`. A halfword store enables lanes 1:0 when `ea[1]` = 0 and lanes 3:2 when `ea[1]` = 1. A word store enables all four lanes. `memWdata` carries the low byte copied into four lanes, the low halfword copied twice, or the whole word.
- R7: A load asserts `loadValid` in the cycle after its request. `loadData` is then the addressed byte or halfword from `memRdata`, zero-extended when `reqSigned` = 0 and sign-extended when it is 1, or the whole word for a word load.
- R8: While `loadValid` = 1, `flagZ` is 1 exactly when `loadData` is zero, `flagN` equals `loadData[31]`, and `flagV` and `flagC` are 0.
- R9: During reset `memReq`, `suspend`, `trapTaken` and `loadValid` are 0.
- R10: A store or a trapped access never produces `loadValid` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Execute stage presents an access this cycle |
| reqIsStore | input | 1 | 1 for a store, 0 for a load |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 treated as word |
| reqSigned | input | 1 | Sign-extend a byte or halfword load |
| reqRelative | input | 1 | 1 selects program counter plus offset addressing |
| baseVal | input | 32 | Base register value for absolute mode |
| offsetVal | input | 32 | Short source operand for absolute mode |
| pcVal | input | 32 | Program counter for relative mode |
| immRel | input | 19 | Signed offset for relative mode |
| storeData | input | 32 | Register value to store |
| memReq | output | 1 | Memory request strobe |
| memWe | output | 1 | Memory write strobe qualifier |
| memAddr | output | 32 | Word address (bits 1:0 zero) |
| memBe | output | 4 | Byte enables for stores |
| memWdata | output | 32 | Lane-replicated store data |
| memRdata | input | 32 | Read word, valid the cycle after a read request |
| suspend | output | 1 | Hold fetch and writeback for this cycle |
| trapTaken | output | 1 | Misaligned access detected |
| trapVector | output | 32 | Trap target address |
| loadValid | output | 1 | Load result available |
| loadData | output | 32 | Extracted and extended load result |
| flagZ | output | 1 | Load result is zero |
| flagN | output | 1 | Load result bit 31 |
| flagV | output | 1 | Cleared on loads |
| flagC | output | 1 | Cleared on loads |

## Verification
A wrong lane index or size held between the request and the data return shows up in the very next cycle: the wrong byte appears on `loadData`, and with it a wrong zero or negative flag. A slip in the misalignment decision shows up at once, in the cycle of the request. It appears either as a memory request that should have been a trap, or as a trap that also leaks `memReq` or `suspend`. Corrupted byte enables on a store stay invisible until a later load reads the same word back. The stimulus therefore pairs stores of each size and lane with loads of the same words.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;    // access goes to memory this cycle
    logic write;    // issued access is a store
    logic capture;  // issued access is a load: remember lane info
  } ctrlStrobe_t;

endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqIsStore,
  input  accSize_e    reqSize,
  input  logic [1:0]  eaLow,
  output ctrlStrobe_t strobe,
  output logic        trapTaken,
  output logic        suspend,
  output logic        loadValid
);

  logic misaligned;
  logic legal;

  always_comb begin
    unique case (reqSize)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = eaLow[0];
      default: misaligned = (eaLow != 2'b00);
    endcase
  end

  assign legal          = reqValid && !misaligned;
  assign trapTaken      = reqValid && misaligned;
  assign strobe.issue   = legal;
  assign strobe.write   = legal && reqIsStore;
  assign strobe.capture = legal && !reqIsStore;
  assign suspend        = legal;

  always_ff @(posedge clk) begin
    if (!rstN) loadValid <= 1'b0;
    else       loadValid <= strobe.capture;
  end

  // R10: a trap cycle is never followed by a load result
  p_trap_noret_r10: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |=> !loadValid);

endmodule

// File: rtl/ldst_dpath.sv
module ldst_dpath
  import ldst_pkg::*;
#(
  parameter int unsigned IMM_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              reqRelative,
  input  accSize_e          reqSize,
  input  logic              reqSigned,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] offsetVal,
  input  logic [DATA_W-1:0] pcVal,
  input  logic [IMM_W-1:0]  immRel,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [1:0]        eaLow,
  output logic [DATA_W-1:0] memAddr,
  output logic [LANES-1:0]  memBe,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadData,
  output logic              flagZ,
  output logic              flagN,
  output logic              flagV,
  output logic              flagC
);

  localparam int unsigned EXT_W  = DATA_W - IMM_W;
  localparam int unsigned HALF_W = 2 * LANE_W;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] effAddr;

  assign immExt  = {{EXT_W{immRel[IMM_W-1]}}, immRel};
  assign effAddr = reqRelative ? (pcVal + immExt) : (baseVal + offsetVal);
  assign eaLow   = effAddr[1:0];
  assign memAddr = {effAddr[DATA_W-1:2], 2'b00};

  // byte enables, one lane per generate step
  for (genvar g = 0; g < LANES; g++) begin : g_be
    localparam logic [1:0] LANE_ID = 2'(g);
    always_comb begin
      unique case (reqSize)
        SZ_BYTE: memBe[g] = (effAddr[1:0] == LANE_ID);
        SZ_HALF: memBe[g] = (effAddr[1] == LANE_ID[1]);
        default: memBe[g] = 1'b1;
      endcase
    end
  end

  always_comb begin
    unique case (reqSize)
      SZ_BYTE: memWdata = {LANES{storeData[LANE_W-1:0]}};
      SZ_HALF: memWdata = {(LANES/2){storeData[HALF_W-1:0]}};
      default: memWdata = storeData;
    endcase
  end

  // remember where the load result lives until the data returns
  logic [1:0] pendLane;
  accSize_e   pendSize;
  logic       pendSigned;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendLane   <= 2'b00;
      pendSize   <= SZ_WORD;
      pendSigned <= 1'b0;
    end else if (strobe.capture) begin
      pendLane   <= effAddr[1:0];
      pendSize   <= reqSize;
      pendSigned <= reqSigned;
    end
  end

  logic [LANE_W-1:0] laneByte [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneByte[g] = memRdata[g*LANE_W +: LANE_W];
  end

  logic [LANE_W-1:0] byteSel;
  logic [HALF_W-1:0] halfSel;

  assign byteSel = laneByte[pendLane];
  assign halfSel = pendLane[1] ? memRdata[DATA_W-1:HALF_W] : memRdata[HALF_W-1:0];

  always_comb begin
    unique case (pendSize)
      SZ_BYTE: loadData = pendSigned ? {{(DATA_W-LANE_W){byteSel[LANE_W-1]}}, byteSel}
                                     : {{(DATA_W-LANE_W){1'b0}}, byteSel};
      SZ_HALF: loadData = pendSigned ? {{(DATA_W-HALF_W){halfSel[HALF_W-1]}}, halfSel}
                                     : {{(DATA_W-HALF_W){1'b0}}, halfSel};
      default: loadData = memRdata;
    endcase
  end

  assign flagZ = (loadData == '0);
  assign flagN = loadData[DATA_W-1];
  assign flagV = 1'b0;
  assign flagC = 1'b0;

  // R2: no word access reaches memory unless word aligned
  p_word_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && (reqSize == SZ_WORD || reqSize == SZ_RSVD)) |-> (effAddr[1:0] == 2'b00));

  // R3: no halfword access reaches memory on an odd address
  p_half_align_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && reqSize == SZ_HALF) |-> !effAddr[0]);

  // R6: a byte store enables exactly one lane, a halfword store two
  p_byte_lane_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.write && reqSize == SZ_BYTE) |-> ($countones(memBe) == 1));
  p_half_lane_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.write && reqSize == SZ_HALF) |-> ($countones(memBe) == 2));

endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int unsigned IMM_W    = 19,
  parameter logic [31:0] TRAP_VEC = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsStore,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic              reqRelative,
  input  logic [31:0]       baseVal,
  input  logic [31:0]       offsetVal,
  input  logic [31:0]       pcVal,
  input  logic [IMM_W-1:0]  immRel,
  input  logic [31:0]       storeData,
  output logic              memReq,
  output logic              memWe,
  output logic [31:0]       memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic              suspend,
  output logic              trapTaken,
  output logic [31:0]       trapVector,
  output logic              loadValid,
  output logic [31:0]       loadData,
  output logic              flagZ,
  output logic              flagN,
  output logic              flagV,
  output logic              flagC
);

  ctrlStrobe_t strobe;
  logic [1:0]  eaLow;
  accSize_e    sizeCode;

  assign sizeCode   = accSize_e'(reqSize);
  assign memReq     = strobe.issue;
  assign memWe      = strobe.write;
  assign trapVector = TRAP_VEC;

  ldst_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqIsStore (reqIsStore),
    .reqSize    (sizeCode),
    .eaLow      (eaLow),
    .strobe     (strobe),
    .trapTaken  (trapTaken),
    .suspend    (suspend),
    .loadValid  (loadValid)
  );

  ldst_dpath #(.IMM_W(IMM_W)) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqRelative (reqRelative),
    .reqSize     (sizeCode),
    .reqSigned   (reqSigned),
    .baseVal     (baseVal),
    .offsetVal   (offsetVal),
    .pcVal       (pcVal),
    .immRel      (immRel),
    .storeData   (storeData),
    .memRdata    (memRdata),
    .eaLow       (eaLow),
    .memAddr     (memAddr),
    .memBe       (memBe),
    .memWdata    (memWdata),
    .loadData    (loadData),
    .flagZ       (flagZ),
    .flagN       (flagN),
    .flagV       (flagV),
    .flagC       (flagC)
  );

  // R4: byte accesses never trap
  p_byte_notrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd0) |-> !trapTaken);

  // R10: a store is never followed by a load result
  p_store_noret_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |=> !loadValid);

  // R7: a load request always returns in the next cycle
  p_load_ret_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |=> loadValid);

endmodule

// File: tb/test_ldst_unit.sv
module test_ldst_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqIsStore = 1'b0, reqSigned = 1'b0, reqRelative = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [31:0] baseVal = '0, offsetVal = '0, pcVal = '0, storeData = '0;
  logic [18:0] immRel = '0;
  logic        memReq, memWe, suspend, trapTaken, loadValid, flagZ, flagN, flagV, flagC;
  logic [31:0] memAddr, memWdata, memRdata, trapVector, loadData;
  logic [3:0]  memBe;

  always #2 clk = ~clk;

  ldst_unit i_ldst_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsStore(reqIsStore),
    .reqSize(reqSize), .reqSigned(reqSigned), .reqRelative(reqRelative),
    .baseVal(baseVal), .offsetVal(offsetVal), .pcVal(pcVal), .immRel(immRel),
    .storeData(storeData), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata), .suspend(suspend),
    .trapTaken(trapTaken), .trapVector(trapVector), .loadValid(loadValid),
    .loadData(loadData), .flagZ(flagZ), .flagN(flagN), .flagV(flagV), .flagC(flagC)
  );

  // memory served to the design
  logic [31:0] ram [64];
  logic [31:0] rdReg = '0;
  assign memRdata = rdReg;
  always @(posedge clk) begin
    if (memReq && memWe) begin
      for (int k = 0; k < 4; k++)
        if (memBe[k]) ram[memAddr[7:2]][8*k +: 8] <= memWdata[8*k +: 8];
    end else if (memReq) begin
      rdReg <= ram[memAddr[7:2]];
    end
  end

  // reference model state
  int unsigned refMem [64];
  int     errors = 0;
  int     checks = 0;
  bit     done = 0;
  bit     expLoadV = 0;
  int unsigned expData = 0;
  string  prevTag = "R9";

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare the registered outputs that belong to the previous cycle
  task automatic checkPrev();
    chk(expLoadV ? "R7" : prevTag, "loadValid", {31'b0, loadValid}, {31'b0, expLoadV});
    if (expLoadV) begin
      chk("R7", "loadData", loadData, expData);
      chk("R8", "flagZ", {31'b0, flagZ}, {31'b0, expData == 0});
      chk("R8", "flagN", {31'b0, flagN}, {31'b0, expData[31]});
      chk("R8", "flagV/C", {30'b0, flagV, flagC}, 32'd0);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    checkPrev();
    reqValid = 1'b0;
    #1;
    chk("R5", "idle memReq", {31'b0, memReq}, 32'd0);
    chk("R5", "idle suspend", {31'b0, suspend}, 32'd0);
    expLoadV = 0;
    prevTag = "R10";
  endtask

  task automatic access(input bit st, input int sz, input bit sgn, input bit rel,
                        input int unsigned base, input int unsigned off,
                        input int unsigned pc, input int imm, input int unsigned sd);
    int unsigned ea, word, lane, v, be, wd;
    bit mis;
    string ttag;
    @(negedge clk);
    checkPrev();
    reqValid = 1'b1; reqIsStore = st; reqSize = 2'(sz); reqSigned = sgn;
    reqRelative = rel; baseVal = base; offsetVal = off; pcVal = pc;
    immRel = 19'(imm); storeData = sd;
    #1;
    ea   = rel ? pc + imm : base + off;
    lane = ea % 4;
    if (sz == 0) begin mis = 0; ttag = "R4"; end
    else if (sz == 1) begin mis = (ea % 2) != 0; ttag = "R3"; end
    else begin mis = lane != 0; ttag = "R2"; end
    chk(ttag, "trapTaken", {31'b0, trapTaken}, {31'b0, mis});
    if (mis) begin
      chk(ttag, "trapVector", trapVector, 32'h8000_0000);
      chk(ttag, "memReq on trap", {30'b0, memReq, suspend}, 32'd0);
      expLoadV = 0;
      prevTag = "R10";
      return;
    end
    chk("R5", "memReq/suspend", {30'b0, memReq, suspend}, 32'd3);
    chk("R5", "memWe", {31'b0, memWe}, {31'b0, st});
    chk("R1", "memAddr", memAddr, ea - lane);
    if (st) begin
      if (sz == 0) begin be = 1 << lane; wd = (sd & 255) * 32'h0101_0101; end
      else if (sz == 1) begin be = (lane >= 2) ? 12 : 3; wd = (sd & 16'hffff) * 32'h0001_0001; end
      else begin be = 15; wd = sd; end
      chk("R6", "memBe", {28'b0, memBe}, be);
      chk("R6", "memWdata", memWdata, wd);
      for (int k = 0; k < 4; k++)
        if ((be >> k) & 1) begin
          refMem[ea/4 % 64] &= ~(32'hff << (8*k));
          refMem[ea/4 % 64] |= wd & (32'hff << (8*k));
        end
      expLoadV = 0;
      prevTag = "R10";
    end else begin
      word = refMem[ea/4 % 64];
      if (sz == 0) begin
        v = (word >> (8*lane)) % 256;
        if (sgn && v >= 128) v = v + 32'hffff_ff00;
      end else if (sz == 1) begin
        v = (word >> (8*lane)) % 65536;
        if (sgn && v >= 32768) v = v + 32'hffff_0000;
      end else v = word;
      expData = v;
      expLoadV = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      refMem[i] = (i * 32'h1357_9bdf) ^ 32'h8a4c_2e60;
      ram[i] = refMem[i];
    end
    refMem[5] = 0; ram[5] = 0;
    refMem[6] = 32'h80f0_7f01; ram[6] = 32'h80f0_7f01;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "reset outputs", {28'b0, memReq, suspend, trapTaken, loadValid}, 32'd0);
    rstN = 1'b1;

    // R1 word loads, absolute and relative (pc 0x40 - 8 = 0x38)
    access(0, 2, 0, 0, 32'h10, 32'h8, 0, 0, 0);
    access(0, 2, 0, 1, 0, 0, 32'h40, -8, 0);
    access(0, 2, 0, 1, 32'hffff, 32'hffff, 32'h100, -200, 0);
    // R8 zero and negative results
    access(0, 2, 0, 0, 32'h14, 0, 0, 0, 0);
    access(0, 2, 0, 0, 32'h18, 0, 0, 0, 0);
    // R7 byte loads on every lane, both extensions
    for (int k = 0; k < 4; k++) begin
      access(0, 0, 0, 0, 32'h18, k, 0, 0, 0);
      access(0, 0, 1, 0, 32'h18, k, 0, 0, 0);
    end
    // R7 halfword loads
    access(0, 1, 0, 0, 32'h18, 2, 0, 0, 0);
    access(0, 1, 1, 0, 32'h18, 2, 0, 0, 0);
    access(0, 1, 1, 0, 32'h18, 0, 0, 0, 0);
    access(0, 1, 0, 1, 0, 0, 32'h20, 2, 0);
    idle();
    // R6 stores of every size then read back
    for (int k = 0; k < 4; k++) access(1, 0, 0, 0, 32'h40, k, 0, 0, 32'h1234_5600 + k * 17 + 120);
    access(0, 2, 0, 0, 32'h40, 0, 0, 0, 0);
    access(1, 1, 0, 0, 32'h44, 2, 0, 0, 32'hdead_beef);
    access(1, 1, 0, 1, 0, 0, 32'h50, -12, 32'h0000_8001);
    access(0, 2, 0, 0, 32'h44, 0, 0, 0, 0);
    access(1, 2, 0, 0, 32'h48, 0, 0, 0, 32'hcafe_f00d);
    access(1, 3, 0, 0, 32'h4c, 0, 0, 0, 32'h0bad_cafe);
    access(0, 2, 0, 0, 32'h48, 0, 0, 0, 0);
    access(0, 3, 0, 0, 32'h4c, 0, 0, 0, 0);
    // R2 R3 misaligned traps, R4 odd byte never traps
    access(0, 2, 0, 0, 32'h40, 1, 0, 0, 0);
    access(1, 2, 0, 0, 32'h40, 2, 0, 0, 32'h1);
    access(0, 3, 0, 1, 0, 0, 32'h40, 3, 0);
    access(0, 1, 0, 0, 32'h41, 0, 0, 0, 0);
    access(1, 1, 0, 1, 0, 0, 32'h40, 3, 32'h5);
    access(0, 0, 1, 0, 32'h41, 2, 0, 0, 0);
    access(1, 0, 0, 0, 32'h47, 0, 0, 0, 32'h99);
    access(0, 2, 0, 0, 32'h44, 0, 0, 0, 0);
    idle();
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule